// File: doc/BRIEF.md
# Initiator Selection and Command-Phase Sequencer

This block runs the initiator side of a select-with-attention operation on a parallel SCSI controller. When a selection operation is issued, it gathers the command descriptor into a local command buffer, decides whether the addressed target exists, and either hands the command to an external execution engine or reports a disconnect. Command bytes come from the controller's byte FIFO (programmed I/O) or from a byte-wide DMA read port. In programmed I/O a zero identify byte is placed ahead of the FIFO bytes.

Two selection flavours exist. The plain one issues the command as soon as the target check passes, waits for the engine to return a signed data length, and posts status, interrupt cause and sequence step. The stop flavour parks in command phase after the target check. FIFO writes made while parked are added to the command buffer. A later transfer operation releases the command, optionally after reading more bytes over DMA. Starting a new selection while a command is still active cancels the old one.

Top module: `scsi_sel_seq`

## Requirements
- R1: After reset, status_o, cause_o and step_o are 0, and irq_o, busy_o, dma_req_o and exec_start_o are low.
- R2: If target_id_i is 7, or bit target_id_i of target_present_i is 0, the selection ends with status 0x80, cause 0x20 and step 0, and irq_o rises. No exec_start_o pulse follows.
- R3: A programmed-I/O selection (op_dma_i=0) with count N and N bytes in the FIFO builds the command 0x00 followed by the N FIFO bytes in order. exec_len_o is then N+1 and exec_lun_o is 0.
- R4: A DMA selection with count N keeps dma_req_o high until N bytes have been taken on cycles with dma_valid_i high. The command is those bytes in order, and exec_lun_o is bits 2:0 of the first byte.
- R5: A plain selection (op_i=0) to a present target gives one exec_start_o pulse. On exec_done_i the block sets cause 0x18 and step 4 and raises irq_o. Status becomes 0x91 if exec_dlen_i is positive and 0x90 if it is negative, and stays unchanged if it is zero. Status bit 7 is interrupt, bit 4 is terminal count, and bits 2:0 are the phase (0 data-out, 1 data-in, 2 command).
- R6: A stop selection (op_i=1) to a present target sets status 0x92, cause 0x18 and step 4, raises irq_o and issues nothing. Each later fifo_we_i byte is appended to the command buffer.
- R7: A transfer operation (op_i=2) while parked issues the buffered command as in R5. With op_dma_i=1 it first reads min(count,32) more DMA bytes, with a count of 0 meaning 32, and appends them.
- R8: The command buffer holds at most 32 bytes. Bytes past the 32nd are dropped, and exec_len_o stays at 32.
- R9: If a selection reaches its target check while a command is active, exec_cancel_o pulses for one cycle. A command becomes active when its target check passes and stays active until exec_end_i.
- R10: Every selection empties the byte FIFO. A DMA selection empties it when the operation is accepted, and a programmed-I/O selection empties it after copying, so no earlier byte reaches a later command.
- R11: irq_ack_i clears irq_o and status bit 7, and leaves cause_o and step_o unchanged.
- R12: A transfer operation when not parked is ignored. It causes no DMA request, no command issue, no busy indication and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation strobe, taken when busy_o is low |
| op_i | input | 2 | 0 select, 1 select-and-stop, 2 transfer |
| op_dma_i | input | 1 | 1: command bytes come over DMA |
| op_count_i | input | CNT_W | Byte count for the operation |
| target_id_i | input | 3 | Addressed target ID |
| target_present_i | input | 7 | One bit per target ID 0 to 6 |
| fifo_we_i | input | 1 | Byte FIFO write strobe |
| fifo_wdata_i | input | 8 | Byte FIFO write data |
| dma_req_o | output | 1 | DMA byte request |
| dma_valid_i | input | 1 | DMA byte valid |
| dma_data_i | input | 8 | DMA byte |
| exec_start_o | output | 1 | One-cycle command issue pulse |
| exec_cancel_o | output | 1 | One-cycle cancel of the active command |
| exec_lun_o | output | 3 | Logical unit from the identify byte |
| exec_len_o | output | LEN_W | Command length in bytes |
| exec_rd_addr_i | input | AW | Command buffer read address |
| exec_rd_data_o | output | 8 | Command buffer read data |
| exec_done_i | input | 1 | Engine has returned a data length |
| exec_dlen_i | input | DL_W | Signed data length; positive is data-in, negative is data-out |
| exec_end_i | input | 1 | Engine finished the active command |
| status_o | output | 8 | Status value |
| cause_o | output | 8 | Interrupt cause |
| step_o | output | 3 | Sequence step |
| irq_o | output | 1 | Interrupt |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| busy_o | output | 1 | Sequencer is collecting, checking or issuing |

## Verification
The assertions assume that the DMA source never drives dma_valid_i while dma_req_o is low, and that the engine asserts exec_done_i once and only after an issue pulse. The bench's DMA server answers only while a request is pending and a byte is queued. Its execution responder drives a single done pulse only after it has seen exec_start_o and read back the buffer. New operations are issued only after every expected interrupt has been consumed, so no strobe arrives while busy_o is high.

// File: rtl/scsi_sel_pkg.sv
package scsi_sel_pkg;
  localparam logic [1:0] OP_SEL      = 2'd0;
  localparam logic [1:0] OP_SEL_STOP = 2'd1;
  localparam logic [1:0] OP_XFER     = 2'd2;

  localparam logic [7:0] ST_IRQ  = 8'h80;
  localparam logic [7:0] ST_TC   = 8'h10;
  localparam logic [2:0] PH_DOUT = 3'd0;
  localparam logic [2:0] PH_DIN  = 3'd1;
  localparam logic [2:0] PH_CMD  = 3'd2;

  localparam logic [7:0] CA_DISC = 8'h20;
  localparam logic [7:0] CA_BUS  = 8'h10;
  localparam logic [7:0] CA_DONE = 8'h08;
  localparam logic [2:0] STEP_CMD = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_PIO_HDR, S_PIO_COPY, S_DMA_RD, S_CHECK,
    S_ISSUE, S_WAIT, S_PARK, S_XFER_DMA
  } sel_state_e;
endpackage

// File: rtl/sel_byte_fifo.sv
module sel_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  input  logic         flush_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop, full;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  // R10
  fifo_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);

  fifo_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i && !flush_i) |=> full);
endmodule

// File: rtl/sel_cmd_buf.sv
module sel_cmd_buf #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o,
  output logic [LW-1:0] len_o,
  output logic [2:0]    lun_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [LW-1:0] len_q;
  logic          room, do_wr;

  assign room    = (len_q < LW'(DEPTH));
  assign do_wr   = we_i && room && !clr_i;
  assign rdata_o = mem_q[raddr_i];
  assign len_o   = len_q;
  assign lun_o   = mem_q[0][2:0];

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[len_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    len_q <= '0;
    else if (clr_i) len_q <= '0;
    else if (do_wr) len_q <= len_q + 1'b1;
  end

  // R8
  buf_saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q == LW'(DEPTH) && we_i && !clr_i) |=> (len_o == LW'(DEPTH)));
endmodule

// File: rtl/sel_ctrl.sv
module sel_ctrl
  import scsi_sel_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DL_W  = 24,
  parameter int DEPTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [1:0]       op_i,
  input  logic             op_dma_i,
  input  logic [CNT_W-1:0] op_count_i,
  input  logic [2:0]       target_id_i,
  input  logic [6:0]       target_present_i,
  input  logic             fifo_we_i,
  input  logic [7:0]       fifo_wdata_i,
  input  logic [7:0]       fifo_rdata_i,
  input  logic             fifo_empty_i,
  output logic             fifo_push_o,
  output logic             fifo_pop_o,
  output logic             fifo_flush_o,
  output logic             buf_clr_o,
  output logic             buf_we_o,
  output logic [7:0]       buf_wdata_o,
  output logic             dma_req_o,
  input  logic             dma_valid_i,
  input  logic [7:0]       dma_data_i,
  output logic             exec_start_o,
  output logic             exec_cancel_o,
  input  logic             exec_done_i,
  input  logic [DL_W-1:0]  exec_dlen_i,
  input  logic             exec_end_i,
  output logic [7:0]       status_o,
  output logic [7:0]       cause_o,
  output logic [2:0]       step_o,
  output logic             irq_o,
  input  logic             irq_ack_i,
  output logic             busy_o
);
  sel_state_e       state_q;
  logic [CNT_W-1:0] remain_q, xfer_cnt;
  logic             stop_q, active_q, irq_q;
  logic [7:0]       status_q, cause_q;
  logic [2:0]       step_q;
  logic             accept_ok, accept_sel, copy_go, tgt_ok, dma_phase;
  logic [7:0]       present_ext;

  assign accept_ok   = op_valid_i && (state_q == S_IDLE || state_q == S_PARK);
  assign accept_sel  = accept_ok && (op_i == OP_SEL || op_i == OP_SEL_STOP);
  assign copy_go     = (state_q == S_PIO_COPY) && (remain_q != '0) && !fifo_empty_i;
  assign present_ext = {1'b0, target_present_i};
  assign tgt_ok      = present_ext[target_id_i];
  assign dma_phase   = (state_q == S_DMA_RD) || (state_q == S_XFER_DMA);
  assign xfer_cnt    = (op_count_i == '0 || op_count_i > CNT_W'(DEPTH)) ?
                       CNT_W'(DEPTH) : op_count_i;

  assign dma_req_o     = dma_phase && (remain_q != '0);
  assign exec_start_o  = (state_q == S_ISSUE);
  assign exec_cancel_o = (state_q == S_CHECK) && active_q;
  assign fifo_push_o   = fifo_we_i && (state_q != S_PARK);
  assign fifo_pop_o    = copy_go;
  assign fifo_flush_o  = (accept_sel && op_dma_i) ||
                         ((state_q == S_PIO_COPY) && !copy_go);
  assign buf_clr_o     = accept_sel;
  assign busy_o        = (state_q != S_IDLE) && (state_q != S_PARK);
  assign status_o      = status_q;
  assign cause_o       = cause_q;
  assign step_o        = step_q;
  assign irq_o         = irq_q;

  always_comb begin
    buf_we_o    = 1'b0;
    buf_wdata_o = 8'h00;
    case (state_q)
      S_PIO_HDR:  buf_we_o = 1'b1;
      S_PIO_COPY: begin
        buf_we_o    = copy_go;
        buf_wdata_o = fifo_rdata_i;
      end
      S_DMA_RD, S_XFER_DMA: begin
        buf_we_o    = dma_valid_i && (remain_q != '0);
        buf_wdata_o = dma_data_i;
      end
      S_PARK: begin
        buf_we_o    = fifo_we_i;
        buf_wdata_o = fifo_wdata_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      remain_q <= '0;
      stop_q   <= 1'b0;
      active_q <= 1'b0;
      irq_q    <= 1'b0;
      status_q <= '0;
      cause_q  <= '0;
      step_q   <= '0;
    end else begin
      if (irq_ack_i) begin
        irq_q       <= 1'b0;
        status_q[7] <= 1'b0;
      end
      if (exec_end_i) active_q <= 1'b0;
      case (state_q)
        S_IDLE, S_PARK: begin
          if (accept_sel) begin
            stop_q   <= (op_i == OP_SEL_STOP);
            remain_q <= op_count_i;
            state_q  <= op_dma_i ? S_DMA_RD : S_PIO_HDR;
          end else if (accept_ok && op_i == OP_XFER && state_q == S_PARK) begin
            if (op_dma_i) begin
              remain_q <= xfer_cnt;
              state_q  <= S_XFER_DMA;
            end else begin
              state_q  <= S_ISSUE;
            end
          end
        end
        S_PIO_HDR: state_q <= S_PIO_COPY;
        S_PIO_COPY: begin
          if (copy_go) remain_q <= remain_q - 1'b1;
          else         state_q  <= S_CHECK;
        end
        S_DMA_RD, S_XFER_DMA: begin
          if (remain_q == '0)   state_q  <= (state_q == S_DMA_RD) ? S_CHECK : S_ISSUE;
          else if (dma_valid_i) remain_q <= remain_q - 1'b1;
        end
        S_CHECK: begin
          if (!tgt_ok) begin
            active_q <= 1'b0;
            status_q <= ST_IRQ;
            cause_q  <= CA_DISC;
            step_q   <= 3'd0;
            irq_q    <= 1'b1;
            state_q  <= S_IDLE;
          end else begin
            active_q <= 1'b1;
            if (stop_q) begin
              status_q <= ST_IRQ | ST_TC | {5'b0, PH_CMD};
              cause_q  <= CA_BUS | CA_DONE;
              step_q   <= STEP_CMD;
              irq_q    <= 1'b1;
              state_q  <= S_PARK;
            end else begin
              state_q  <= S_ISSUE;
            end
          end
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: begin
          if (exec_done_i) begin
            if (exec_dlen_i != '0)
              status_q <= ST_IRQ | ST_TC |
                          {5'b0, exec_dlen_i[DL_W-1] ? PH_DOUT : PH_DIN};
            cause_q <= CA_BUS | CA_DONE;
            step_q  <= STEP_CMD;
            irq_q   <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R5
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |=> !exec_start_o);

  // R9
  cancel_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_cancel_o |=> !exec_cancel_o);

  // R2
  disc_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && cause_o == CA_DISC) |-> (status_o == ST_IRQ && step_o == 3'd0));

  // R4
  dma_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && !dma_valid_i) |=> dma_req_o);

  // R6
  park_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && status_o[2:0] == PH_CMD && !busy_o) |-> (step_o == STEP_CMD));
endmodule

// File: rtl/scsi_sel_seq.sv
module scsi_sel_seq
  import scsi_sel_pkg::*;
#(
  parameter int  CNT_W = 16,
  parameter int  DL_W  = 24,
  parameter int  DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [1:0]       op_i,
  input  logic             op_dma_i,
  input  logic [CNT_W-1:0] op_count_i,
  input  logic [2:0]       target_id_i,
  input  logic [6:0]       target_present_i,
  input  logic             fifo_we_i,
  input  logic [7:0]       fifo_wdata_i,
  output logic             dma_req_o,
  input  logic             dma_valid_i,
  input  logic [7:0]       dma_data_i,
  output logic             exec_start_o,
  output logic             exec_cancel_o,
  output logic [2:0]       exec_lun_o,
  output logic [LEN_W-1:0] exec_len_o,
  input  logic [AW-1:0]    exec_rd_addr_i,
  output logic [7:0]       exec_rd_data_o,
  input  logic             exec_done_i,
  input  logic [DL_W-1:0]  exec_dlen_i,
  input  logic             exec_end_i,
  output logic [7:0]       status_o,
  output logic [7:0]       cause_o,
  output logic [2:0]       step_o,
  output logic             irq_o,
  input  logic             irq_ack_i,
  output logic             busy_o
);
  logic       fifo_push, fifo_pop, fifo_flush, fifo_empty;
  logic [7:0] fifo_rdata;
  logic       buf_clr, buf_we;
  logic [7:0] buf_wdata;

  sel_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .wdata_i (fifo_wdata_i),
    .pop_i   (fifo_pop),
    .flush_i (fifo_flush),
    .rdata_o (fifo_rdata),
    .empty_o (fifo_empty)
  );

  sel_cmd_buf #(.DEPTH(DEPTH), .W(8)) u_cbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (buf_clr),
    .we_i    (buf_we),
    .wdata_i (buf_wdata),
    .raddr_i (exec_rd_addr_i),
    .rdata_o (exec_rd_data_o),
    .len_o   (exec_len_o),
    .lun_o   (exec_lun_o)
  );

  sel_ctrl #(.CNT_W(CNT_W), .DL_W(DL_W), .DEPTH(DEPTH)) u_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .op_valid_i       (op_valid_i),
    .op_i             (op_i),
    .op_dma_i         (op_dma_i),
    .op_count_i       (op_count_i),
    .target_id_i      (target_id_i),
    .target_present_i (target_present_i),
    .fifo_we_i        (fifo_we_i),
    .fifo_wdata_i     (fifo_wdata_i),
    .fifo_rdata_i     (fifo_rdata),
    .fifo_empty_i     (fifo_empty),
    .fifo_push_o      (fifo_push),
    .fifo_pop_o       (fifo_pop),
    .fifo_flush_o     (fifo_flush),
    .buf_clr_o        (buf_clr),
    .buf_we_o         (buf_we),
    .buf_wdata_o      (buf_wdata),
    .dma_req_o        (dma_req_o),
    .dma_valid_i      (dma_valid_i),
    .dma_data_i       (dma_data_i),
    .exec_start_o     (exec_start_o),
    .exec_cancel_o    (exec_cancel_o),
    .exec_done_i      (exec_done_i),
    .exec_dlen_i      (exec_dlen_i),
    .exec_end_i       (exec_end_i),
    .status_o         (status_o),
    .cause_o          (cause_o),
    .step_o           (step_o),
    .irq_o            (irq_o),
    .irq_ack_i        (irq_ack_i),
    .busy_o           (busy_o)
  );
endmodule

// File: tb/scsi_sel_seq_tb.sv
module scsi_sel_seq_tb;
  import scsi_sel_pkg::*;
  localparam int CNT_W = 16;
  localparam int DL_W  = 24;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             op_valid = 1'b0, op_dma = 1'b0;
  logic [1:0]       op_code = '0;
  logic [CNT_W-1:0] op_count = '0;
  logic [2:0]       tgt_id = '0;
  logic [6:0]       tgt_pres = '0;
  logic             fifo_we = 1'b0;
  logic [7:0]       fifo_wdata = '0;
  logic             dma_req, dma_valid = 1'b0;
  logic [7:0]       dma_data = '0;
  logic             exec_start, exec_cancel, exec_done = 1'b0, exec_end = 1'b0;
  logic [2:0]       exec_lun;
  logic [5:0]       exec_len;
  logic [4:0]       rd_addr = '0;
  logic [7:0]       rd_data;
  logic [DL_W-1:0]  exec_dlen = '0;
  logic [7:0]       status, cause;
  logic [2:0]       step;
  logic             irq, irq_ack = 1'b0, busy;

  scsi_sel_seq #(.CNT_W(CNT_W), .DL_W(DL_W), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op_code),
    .op_dma_i(op_dma), .op_count_i(op_count), .target_id_i(tgt_id),
    .target_present_i(tgt_pres), .fifo_we_i(fifo_we), .fifo_wdata_i(fifo_wdata),
    .dma_req_o(dma_req), .dma_valid_i(dma_valid), .dma_data_i(dma_data),
    .exec_start_o(exec_start), .exec_cancel_o(exec_cancel), .exec_lun_o(exec_lun),
    .exec_len_o(exec_len), .exec_rd_addr_i(rd_addr), .exec_rd_data_o(rd_data),
    .exec_done_i(exec_done), .exec_dlen_i(exec_dlen), .exec_end_i(exec_end),
    .status_o(status), .cause_o(cause), .step_o(step), .irq_o(irq),
    .irq_ack_i(irq_ack), .busy_o(busy)
  );

  typedef struct packed {
    logic [7:0] st;
    logic [7:0] ca;
    logic [2:0] sp;
  } irq_item_t;

  typedef struct packed {
    logic [2:0]        lun;
    logic [5:0]        len;
    logic [31:0][7:0]  b;
    logic [DL_W-1:0]   dlen;
  } cmd_item_t;

  irq_item_t  irq_q[$];
  cmd_item_t  cmd_q[$];
  logic [7:0] dma_q[$];
  int n_run = 0, n_fail = 0, n_starts = 0, n_cancel = 0;
  logic prev_irq = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // irq monitor: compare fields on each interrupt rise
  initial forever begin
    @(negedge clk);
    if (irq && !prev_irq) begin
      if (irq_q.size() == 0) chk(0, "R5 unexpected irq", {24'h0, cause}, 32'h0);
      else begin
        irq_item_t it;
        it = irq_q.pop_front();
        chk(status == it.st, "R5 status", {24'h0, status}, {24'h0, it.st});
        chk(cause == it.ca, "R5 cause", {24'h0, cause}, {24'h0, it.ca});
        chk(step == it.sp, "R5 step", {29'h0, step}, {29'h0, it.sp});
      end
    end
    prev_irq = irq;
  end

  // execution responder: checks the issued command, returns a data length
  initial forever begin
    @(negedge clk);
    if (exec_start) begin
      n_starts++;
      if (cmd_q.size() == 0) chk(0, "R5 unexpected issue", {26'h0, exec_len}, 32'h0);
      else begin
        cmd_item_t it;
        it = cmd_q.pop_front();
        chk(exec_lun == it.lun, "R4 lun", {29'h0, exec_lun}, {29'h0, it.lun});
        chk(exec_len == it.len, "R3 length", {26'h0, exec_len}, {26'h0, it.len});
        for (int k = 0; k < int'(it.len); k++) begin
          rd_addr = 5'(k);
          #1;
          chk(rd_data == it.b[k], "R3 command byte", {24'h0, rd_data}, {24'h0, it.b[k]});
        end
        @(negedge clk);
        exec_dlen = it.dlen;
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (exec_cancel) n_cancel++;
  end

  // DMA server
  initial forever begin
    @(negedge clk);
    if (dma_req && dma_q.size() > 0) begin
      dma_valid = 1'b1;
      dma_data  = dma_q.pop_front();
    end else dma_valid = 1'b0;
  end

  task automatic do_op(input logic [1:0] o, input bit dma, input int cnt);
    @(negedge clk);
    op_valid = 1'b1; op_code = o; op_dma = dma; op_count = CNT_W'(cnt);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    fifo_we = 1'b1; fifo_wdata = d;
    @(negedge clk);
    fifo_we = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); exec_end = 1'b1;
    @(negedge clk); exec_end = 1'b0;
  endtask

  task automatic drain();
    while (irq_q.size() != 0 || cmd_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic exp_irq(input logic [7:0] st, input logic [7:0] ca, input logic [2:0] sp);
    irq_item_t it;
    it.st = st; it.ca = ca; it.sp = sp;
    irq_q.push_back(it);
  endtask

  task automatic exp_cmd(input logic [2:0] lun, input int len, input logic [31:0][7:0] b, input int dlen);
    cmd_item_t it;
    it.lun = lun; it.len = 6'(len); it.b = b; it.dlen = DL_W'(dlen);
    cmd_q.push_back(it);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 32'h0, 32'h1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0][7:0] b;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status == 8'h00 && cause == 8'h00 && step == 3'd0, "R1 fields", {16'h0, status, cause}, 32'h0);
    chk(!irq && !busy && !dma_req && !exec_start, "R1 controls", {28'h0, irq, busy, dma_req, exec_start}, 32'h0);

    // R12 transfer while idle is ignored
    do_op(OP_XFER, 1'b1, 3);
    seen = 1'b0;
    repeat (6) begin @(negedge clk); if (dma_req || exec_start || busy) seen = 1'b1; end
    chk(!seen, "R12 no activity", {31'h0, seen}, 32'h0);
    chk(status == 8'h00 && !irq, "R12 status kept", {23'h0, irq, status}, 32'h0);

    // R2 absent target
    tgt_id = 3'd3; tgt_pres = 7'b1110111;
    exp_irq(8'h80, 8'h20, 3'd0);
    do_op(OP_SEL, 1'b0, 0);
    drain();
    chk(n_starts == 0, "R2 no issue", n_starts, 0);
    pulse_ack();
    @(negedge clk);
    // R11 ack clears irq and status bit 7 only
    chk(!irq && status == 8'h00, "R11 ack", {23'h0, irq, status}, 32'h0);
    chk(cause == 8'h20 && step == 3'd0, "R11 cause kept", {24'h0, cause}, 32'h20);

    // R2 target id 7 never present
    tgt_id = 3'd7; tgt_pres = 7'h7F;
    dma_q.push_back(8'h11); dma_q.push_back(8'h22);
    exp_irq(8'h80, 8'h20, 3'd0);
    do_op(OP_SEL_STOP, 1'b1, 2);
    drain();
    chk(n_starts == 0, "R2 id7 no issue", n_starts, 0);
    pulse_ack();

    // R3 programmed I/O selection
    tgt_id = 3'd1;
    push(8'hA1); push(8'hB2); push(8'hC3);
    b = '0; b[0] = 8'h00; b[1] = 8'hA1; b[2] = 8'hB2; b[3] = 8'hC3;
    exp_cmd(3'd0, 4, b, 512);
    exp_irq(8'h91, 8'h18, 3'd4);
    do_op(OP_SEL, 1'b0, 3);
    drain();
    chk(n_starts == 1, "R5 one issue", n_starts, 1);
    pulse_ack();
    @(negedge clk);
    chk(status == 8'h11, "R11 status bit7 cleared", {24'h0, status}, 32'h11);
    pulse_end();

    // R4 DMA selection, negative length
    dma_q = '{8'h05, 8'h12, 8'h34, 8'h56, 8'h78};
    b = '0; b[0] = 8'h05; b[1] = 8'h12; b[2] = 8'h34; b[3] = 8'h56; b[4] = 8'h78;
    exp_cmd(3'd5, 5, b, -8);
    exp_irq(8'h90, 8'h18, 3'd4);
    do_op(OP_SEL, 1'b1, 5);
    drain();
    chk(n_cancel == 0, "R9 no cancel when idle", n_cancel, 0);
    pulse_ack();

    // R6 stop variant with DMA, R10 stale FIFO bytes flushed, R9 cancel
    push(8'hEE); push(8'hFF);
    tgt_id = 3'd2;
    dma_q = '{8'h02, 8'h03};
    exp_irq(8'h92, 8'h18, 3'd4);
    do_op(OP_SEL_STOP, 1'b1, 2);
    drain();
    chk(n_cancel == 1, "R9 cancel on reselect", n_cancel, 1);
    chk(n_starts == 2, "R6 park issues nothing", n_starts, 2);
    pulse_ack();
    push(8'h44); push(8'h55);
    b = '0; b[0] = 8'h02; b[1] = 8'h03; b[2] = 8'h44; b[3] = 8'h55;
    exp_cmd(3'd2, 4, b, 0);
    exp_irq(8'h12, 8'h18, 3'd4);  // R5 zero length keeps status
    do_op(OP_XFER, 1'b0, 0);
    drain();
    pulse_ack();
    push(8'h77);
    b = '0; b[0] = 8'h00; b[1] = 8'h77;
    exp_cmd(3'd0, 2, b, 3);
    exp_irq(8'h91, 8'h18, 3'd4);
    do_op(OP_SEL, 1'b0, 1);  // R10 EE/FF must not appear
    drain();
    chk(n_cancel == 2, "R9 second cancel", n_cancel, 2);
    pulse_ack();

    // R8 saturation at 32 bytes
    for (int k = 0; k < 31; k++) push(8'(k + 1));
    exp_irq(8'h92, 8'h18, 3'd4);
    do_op(OP_SEL_STOP, 1'b0, 31);
    drain();
    chk(n_cancel == 3, "R9 third cancel", n_cancel, 3);
    pulse_ack();
    push(8'hA0); push(8'hA1);
    dma_q = '{8'hB0, 8'hB1, 8'hB2, 8'hB3};
    b = '0;
    for (int k = 1; k < 32; k++) b[k] = 8'(k);
    exp_cmd(3'd0, 32, b, 1);
    exp_irq(8'h91, 8'h18, 3'd4);
    do_op(OP_XFER, 1'b1, 4);
    drain();
    chk(dma_q.size() == 0 && !dma_req, "R8 excess DMA bytes taken and dropped", dma_q.size(), 0);
    pulse_ack();
    pulse_end();

    // R7 DMA transfer appends to parked command
    push(8'h09);
    exp_irq(8'h92, 8'h18, 3'd4);
    do_op(OP_SEL_STOP, 1'b0, 1);
    drain();
    chk(n_cancel == 3, "R9 no cancel after end", n_cancel, 3);
    pulse_ack();
    dma_q = '{8'h61, 8'h62};
    b = '0; b[0] = 8'h00; b[1] = 8'h09; b[2] = 8'h61; b[3] = 8'h62;
    exp_cmd(3'd0, 4, b, -1);
    exp_irq(8'h90, 8'h18, 3'd4);
    do_op(OP_XFER, 1'b1, 2);
    drain();
    pulse_ack();
    chk(n_starts == 6, "R7 total issues", n_starts, 6);
    chk(irq_q.size() == 0 && cmd_q.size() == 0, "R5 all events seen", irq_q.size() + cmd_q.size(), 0);

    summary();
    $finish;
  end
endmodule